// File: doc/BRIEF.md
# Space-Character Baud Tracker

This block listens to an asynchronous serial receive line and derives the bit-period divisor from the ASCII space characters in ordinary traffic. It needs no separate lock phase. Every well-formed space that passes the checks replaces the stored divisor, however long ago the previous one arrived. A companion receiver takes the divisor and uses it to sample bytes. The frame is 8N1, least significant bit first.

A space on the wire shows a fixed shape:
- a low run of six bit times (the start bit plus five zero data bits);
- a high run of one bit time;
- a low run of two bit times;
- the high stop bit.

The block measures every run of the synchronised line. It keeps the last completed low run and the high run after it. When a low run ends, it tests the three most recent runs against that shape. An accepted measurement is published at the start of the stop bit, so the receiver can take a start bit that follows at once. A byte that does not match leaves the divisor alone, and the window simply slides on to the next run. For this reason no alignment to byte boundaries is needed.

Top module: `space_autobaud`

## Requirements
- R1: While reset is asserted and after its release, `divisor` is 0 and `div_valid` and `div_update` are 0 until a space is accepted.
- R2: For an accepted pattern whose first low run lasts L clocks, `divisor` becomes floor((L+3)/6) and `div_valid` becomes 1. `div_update` pulses high for exactly one clock in the same cycle.
- R3: Every accepted space replaces the divisor, including a later space at a different bit rate.
- R4: Let L be the first low run, H the high run after it, and C the second low run. A pattern is accepted only if all of these hold: 8·H ≥ L, 24·H ≤ 5·L, 4·C ≥ L and 12·C ≤ 5·L. Otherwise no pulse occurs and the divisor keeps its old value. Non-space bytes such as 0x41, 0x55 and 0x00 therefore cause no update.
- R5: A pattern with L below 24 clocks (a bit period under 4 clocks) is ignored, even if its proportions fit. L = 24 is accepted.
- R6: There is no inactivity timeout. After an idle gap of any length, `div_valid` and `divisor` are unchanged, and the next space is accepted.
- R7: A space embedded in back-to-back bytes, with no idle time between frames, is accepted. No earlier sync stage is needed.
- R8: `div_update` is high after the third rising clock edge that samples the line high at the end of the two-bit low run. It is low after the second. This lies within the stop bit for any period of 4 clocks or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_async | input | 1 | Serial receive line, not synchronised, idle high |
| divisor | output | DW (32) | Bit period in clocks from the last accepted space |
| div_valid | output | 1 | High once a space has been accepted |
| div_update | output | 1 | One-clock pulse when the divisor is loaded |

## Verification
Spaces are sent at several bit periods so that each replacement can be told apart from a stale value. Non-space bytes whose run structure is close to that of a space show that the shape test rejects them. Hand-made run triples sit exactly on, and one clock outside, each tolerance limit and the minimum-period limit; these locate the comparison boundaries. A long idle gap shows that nothing expires, and a string of back-to-back bytes shows that tracking works in the middle of traffic. A behavioural model of the run lengths predicts all three outputs on every clock, which pins down the publication cycle.

// File: rtl/abd_pkg.sv
package abd_pkg;
  // bit times of the opening low run of a space: start bit plus five zero bits
  localparam int unsigned FIRST_LOW_BITS = 6;
  // half of FIRST_LOW_BITS, used to round the divide to nearest
  localparam int unsigned ROUND_ADD      = FIRST_LOW_BITS / 2;
  localparam logic        LINE_IDLE      = 1'b1;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise,
  output logic fall
);
  import abd_pkg::*;

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;
  logic              level;

  assign level = sh_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = d_async;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{LINE_IDLE}};
      prev_q <= LINE_IDLE;
    end else begin
      sh_q   <= sh_d;
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/abd_run_ctr.sv
module abd_run_ctr #(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] run_len
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != {CW{1'b1}});
    cnt_d  = restart ? CW'(1) : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_len = cnt_q;
endmodule

// File: rtl/abd_judge.sv
module abd_judge #(
  parameter int unsigned CW      = 20,
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_BIT = 4
) (
  input  logic [CW-1:0] low_a,
  input  logic [CW-1:0] high_b,
  input  logic [CW-1:0] low_c,
  output logic          accept,
  output logic [DW-1:0] div_new
);
  import abd_pkg::*;

  localparam int unsigned EW    = CW + 5;
  localparam int unsigned MIN_L = FIRST_LOW_BITS * MIN_BIT;

  logic [EW-1:0] a_x, h_x, c_x, a5, h24, c12, q;
  logic          long_enough, high_ok, low_ok;

  always_comb begin
    a_x = EW'(low_a);
    h_x = EW'(high_b);
    c_x = EW'(low_c);
    a5  = (a_x << 2) + a_x;
    h24 = (h_x << 4) + (h_x << 3);
    c12 = (c_x << 3) + (c_x << 2);
    long_enough = a_x >= EW'(MIN_L);
    high_ok     = ((h_x << 3) >= a_x) && (h24 <= a5);
    low_ok      = ((c_x << 2) >= a_x) && (c12 <= a5);
    accept      = long_enough && high_ok && low_ok;
    q           = (a_x + EW'(ROUND_ADD)) / EW'(FIRST_LOW_BITS);
    div_new     = DW'(q);
  end
endmodule

// File: rtl/space_autobaud.sv
module space_autobaud #(
  parameter int unsigned CW      = 20,
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_BIT = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_async,
  output logic [DW-1:0] divisor,
  output logic          div_valid,
  output logic          div_update
);
  logic          rise, fall;
  logic [CW-1:0] run_len;
  logic          accept;
  logic [DW-1:0] div_new;

  logic [CW-1:0] low_a_q, low_a_d, high_b_q, high_b_d;
  logic [DW-1:0] div_q, div_d;
  logic          val_q, val_d, upd_q, upd_d;
  logic          take;

  abd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_async), .rise(rise), .fall(fall)
  );

  abd_run_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(rise | fall), .run_len(run_len)
  );

  abd_judge #(.CW(CW), .DW(DW), .MIN_BIT(MIN_BIT)) u_judge (
    .low_a(low_a_q), .high_b(high_b_q), .low_c(run_len),
    .accept(accept), .div_new(div_new)
  );

  always_comb begin
    take     = rise & accept;
    low_a_d  = rise ? run_len : low_a_q;
    high_b_d = fall ? run_len : high_b_q;
    div_d    = take ? div_new : div_q;
    val_d    = val_q | take;
    upd_d    = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_a_q  <= '0;
      high_b_q <= '0;
      div_q    <= '0;
      val_q    <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      if (rise) low_a_q  <= low_a_d;
      if (fall) high_b_q <= high_b_d;
      if (take) div_q    <= div_d;
      val_q <= val_d;
      upd_q <= upd_d;
    end
  end

  assign divisor    = div_q;
  assign div_valid  = val_q;
  assign div_update = upd_q;
endmodule

// File: rtl/space_autobaud_chk.sv
module space_autobaud_chk #(
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] divisor,
  input logic          div_valid,
  input logic          div_update
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) div_update |=> !div_update); // R2
  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(div_valid) |-> div_update); // R2
  AST_UPD_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) div_update |-> div_valid); // R2
  AST_DIV_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(divisor) |-> div_update); // R4
  AST_VALID_KEPT: assert property (@(posedge clk) disable iff (!rst_n) div_valid |=> div_valid); // R6
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) div_valid |-> (divisor >= DW'(MIN_BIT))); // R5
endmodule

bind space_autobaud space_autobaud_chk #(.DW(DW), .MIN_BIT(MIN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor),
  .div_valid(div_valid), .div_update(div_update)
);

// File: tb/tb_space_autobaud.sv
`timescale 1ns/1ps
module tb_space_autobaud;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [31:0] divisor;
  logic        div_valid, div_update;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  space_autobaud dut (
    .clk(clk), .rst_n(rst_n), .rx_async(rx),
    .divisor(divisor), .div_valid(div_valid), .div_update(div_update)
  );

  // behavioural model of run lengths on the driven line
  int  m_prev, m_run, m_la, m_hb, m_div, m_val, m_upd;
  int  e_div[3];
  int  e_val[3];
  int  e_upd[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 1; m_run = 0; m_la = 0; m_hb = 0;
      m_div = 0; m_val = 0; m_upd = 0;
      for (int i = 0; i < 3; i++) begin e_div[i] = 0; e_val[i] = 0; e_upd[i] = 0; end
    end else begin
      m_upd = 0;
      if (int'(rx) != m_prev) begin
        if (rx) begin
          if (m_la >= 24 && 8*m_hb >= m_la && 24*m_hb <= 5*m_la &&
              4*m_run >= m_la && 12*m_run <= 5*m_la) begin
            m_div = (m_la + 3) / 6; m_val = 1; m_upd = 1;
          end
          m_la = m_run;
        end else begin
          m_hb = m_run;
        end
        m_run = 1;
      end else begin
        m_run++;
      end
      m_prev = int'(rx);
      e_div[2] = e_div[1]; e_div[1] = e_div[0]; e_div[0] = m_div;
      e_val[2] = e_val[1]; e_val[1] = e_val[0]; e_val[0] = m_val;
      e_upd[2] = e_upd[1]; e_upd[1] = e_upd[0]; e_upd[0] = m_upd;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(int'(divisor) == e_div[2], "R2 R3 R4 divisor vs model", int'(divisor), e_div[2]);
      chk(int'(div_valid) == e_val[2], "R1 R6 valid vs model", int'(div_valid), e_val[2]);
      chk(int'(div_update) == e_upd[2], "R8 update vs model", int'(div_update), e_upd[2]);
    end
  end

  task automatic hold(input bit v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int p);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(b[i], p);
    hold(1'b1, p);
  endtask

  task automatic send_runs(input int la, input int hb, input int lc);
    hold(1'b0, la);
    hold(1'b1, hb);
    hold(1'b0, lc);
    hold(1'b1, 40);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(divisor == 0 && !div_valid && !div_update, "R1 outputs in reset",
        int'(divisor) + int'(div_valid) + int'(div_update), 0);
    rst_n = 1'b1;
    hold(1'b1, 30);
    chk(!div_valid && divisor == 0, "R1 idle after reset", int'(div_valid), 0);

    // R8: publication timing inside the stop bit, period 10
    hold(1'b0, 60); hold(1'b1, 10); hold(1'b0, 20);
    rx = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!div_update, "R8 no pulse after two edges", int'(div_update), 0);
    @(negedge clk);
    chk(div_update == 1'b1, "R8 pulse after third edge", int'(div_update), 1);
    @(negedge clk);
    chk(!div_update, "R2 pulse one clock wide", int'(div_update), 0);
    hold(1'b1, 20);
    chk(divisor == 10 && div_valid, "R2 space period 10", int'(divisor), 10);

    send_byte(8'h20, 17); hold(1'b1, 20);
    chk(divisor == 17, "R3 second space period 17", int'(divisor), 17);
    send_byte(8'h20, 8); hold(1'b1, 20);
    chk(divisor == 8, "R3 third space period 8", int'(divisor), 8);

    send_byte(8'h41, 12); send_byte(8'h55, 12); send_byte(8'h00, 12); hold(1'b1, 20);
    chk(divisor == 8, "R4 non-space bytes ignored", int'(divisor), 8);

    // tolerance edges around L=72
    send_runs(72, 8, 24);
    chk(divisor == 8, "R4 high run short", int'(divisor), 8);
    send_runs(72, 16, 24);
    chk(divisor == 8, "R4 high run long", int'(divisor), 8);
    send_runs(72, 12, 17);
    chk(divisor == 8, "R4 second low short", int'(divisor), 8);
    send_runs(72, 12, 31);
    chk(divisor == 8, "R4 second low long", int'(divisor), 8);
    send_runs(72, 9, 18);
    chk(divisor == 12, "R4 lower limits accepted", int'(divisor), 12);
    send_runs(90, 18, 37);
    chk(divisor == 15, "R4 upper limits accepted", int'(divisor), 15);

    // minimum period
    send_byte(8'h20, 3); hold(1'b1, 20);
    chk(divisor == 15, "R5 period 3 ignored", int'(divisor), 15);
    send_runs(23, 4, 8);
    chk(divisor == 15, "R5 L=23 ignored", int'(divisor), 15);
    send_runs(24, 4, 8);
    chk(divisor == 4, "R5 L=24 accepted", int'(divisor), 4);

    // long idle, no timeout
    hold(1'b1, 20000);
    chk(div_valid && divisor == 4, "R6 retained after idle", int'(divisor), 4);
    send_byte(8'h20, 20); hold(1'b1, 20);
    chk(divisor == 20, "R6 space after idle", int'(divisor), 20);

    // back-to-back traffic
    send_byte(8'h61, 9); send_byte(8'h20, 9); send_byte(8'h62, 9); hold(1'b1, 20);
    chk(divisor == 9, "R7 space inside traffic", int'(divisor), 9);

    finish_run();
  end
endmodule